// File: doc/BRIEF.md
# Audio Codec Register File with Command Port

This block models the control registers of a stereo audio codec as seen through one 32-bit command register. Software writes a command word. Bit 23 of that word chooses between storing data into a 16-bit codec register and fetching one. Either way, the command register is rewritten one clock later. After a fetch it holds the addressed register's contents together with a data-valid flag. After a store it holds an echo of the written command.

The codec registers sit at even byte addresses from 0x00 to 0x7E. Each register applies its own rule when it is stored into:
- the two output volume registers drop their unused bits;
- the power-down register keeps its status byte;
- the identification registers cannot be written;
- the extended control register accepts only its variable-rate enable bit.

The two sample-rate registers accept a new value only while variable rate is enabled. A value written to them is rounded to the nearest supported rate. Turning variable rate off puts both rate registers back to 48000.

Top module: `codec_cmd_regfile`

## Requirements
- R1: After reset the command register reads 0, and the codec registers hold these values: 0x00=0x6A90, 0x02=0x8000, 0x04=0x8000, 0x06=0x8000, 0x0C=0x8008, 0x0E=0x8008, 0x10=0x8808, 0x12=0x8808, 0x14=0x8808, 0x16=0x8808, 0x18=0x8808, 0x1C=0x8000, 0x26=0x000F, 0x28=0x0A05, 0x2A=0x0400, 0x2C=48000, 0x32=48000, 0x7C=0x8384, 0x7E=0x7666. Every other address holds 0.
- R2: A store command has bit 23 = 0, the address in bits 22:16 and the data in bits 15:0. One cycle later the command register holds the command word ANDed with 0xC0FFFFFF. An address with no special rule stores all 16 data bits.
- R3: A fetch command has bit 23 = 1. One cycle later the command register holds:
  - bits 31:30 and 23:16 of the command word;
  - bit 25 set;
  - the addressed register in bits 15:0;
  - zero in bits 29:26 and 24.
- R4: Stores to 0x02 and 0x18 are ANDed with 0x9F1F.
- R5: A store to 0x2A changes only bit 0 (variable-rate enable). All other bits keep their value.
- R6: A store to 0x2A with bit 0 = 0 also sets 0x2C and 0x32 to 48000.
- R7: While 0x2A bit 0 is 0, stores to 0x2C and 0x32 are ignored.
- R8: While variable rate is enabled, a store to 0x2C or 0x32 is rounded to the nearest of 8000, 11025, 16000, 22050, 32000, 44100 and 48000. A value below the integer midpoint of two neighbours takes the lower one. A value at or above the midpoint moves on to the higher one.
- R9: A store to 0x26 updates bits 15:8 only. Bits 7:0 keep their value.
- R10: Stores to 0x28, 0x7C and 0x7E have no effect.
- R11: An odd address selects the 16-bit register at the even address just below it.
- R12: The command register holds its value in cycles with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 32 | Command word |
| cmd_rdata_o | output | 32 | Command register contents |

## Verification
The assertions check the following on every cycle:
- the command register's echo format after stores and after fetches;
- that the command register holds while idle;
- that a fetch of the identification registers always returns their fixed values;
- that a fetched volume register never shows a masked bit;
- that a fetched rate register always holds a member of the supported list.

Other behaviour depends on history that only the bench's scenarios can show:
- the midpoint cutoffs at each rate boundary;
- stores ignored while variable rate is off, and the reset of both rates when it is cleared;
- the preserved power-down status byte;
- odd-address aliasing.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 7;
  localparam int IDX_W    = ADDR_W - 1;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int NUM_RATES = 7;

  localparam logic [CMD_W-1:0] WR_KEEP_MASK = 32'hC0FF_FFFF;
  localparam logic [CMD_W-1:0] RD_KEEP_MASK = 32'hC0FF_0000;
  localparam int RD_VALID_BIT = 25;
  localparam int RD_SEL_BIT   = 23;
  localparam logic [DATA_W-1:0] VOL_MASK = 16'h9F1F;

  localparam logic [DATA_W-1:0] RATE_TBL [NUM_RATES] =
    '{16'd8000, 16'd11025, 16'd16000, 16'd22050, 16'd32000, 16'd44100, 16'd48000};
  localparam logic [DATA_W-1:0] RATE_MAX = RATE_TBL[NUM_RATES-1];

  // register indices (byte address / 2)
  localparam logic [IDX_W-1:0] IDX_RESET    = 6'h00;
  localparam logic [IDX_W-1:0] IDX_MAIN_VOL = 6'h01;
  localparam logic [IDX_W-1:0] IDX_HP_VOL   = 6'h02;
  localparam logic [IDX_W-1:0] IDX_MONO_VOL = 6'h03;
  localparam logic [IDX_W-1:0] IDX_PHONE    = 6'h06;
  localparam logic [IDX_W-1:0] IDX_MIC      = 6'h07;
  localparam logic [IDX_W-1:0] IDX_LINE     = 6'h08;
  localparam logic [IDX_W-1:0] IDX_CD       = 6'h09;
  localparam logic [IDX_W-1:0] IDX_VIDEO    = 6'h0A;
  localparam logic [IDX_W-1:0] IDX_AUX      = 6'h0B;
  localparam logic [IDX_W-1:0] IDX_PCM_VOL  = 6'h0C;
  localparam logic [IDX_W-1:0] IDX_REC_GAIN = 6'h0E;
  localparam logic [IDX_W-1:0] IDX_PWR      = 6'h13;
  localparam logic [IDX_W-1:0] IDX_EXT_ID   = 6'h14;
  localparam logic [IDX_W-1:0] IDX_EXT_CTRL = 6'h15;
  localparam logic [IDX_W-1:0] IDX_DAC_RATE = 6'h16;
  localparam logic [IDX_W-1:0] IDX_ADC_RATE = 6'h19;
  localparam logic [IDX_W-1:0] IDX_ID_HI    = 6'h3E;
  localparam logic [IDX_W-1:0] IDX_ID_LO    = 6'h3F;

  typedef enum logic [2:0] {
    RULE_FULL, RULE_VOL, RULE_EXT_CTRL, RULE_RATE, RULE_PWR, RULE_RO
  } wr_rule_e;

  function automatic logic [DATA_W-1:0] reg_default(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_RESET:                              return 16'h6A90;
      IDX_MAIN_VOL, IDX_HP_VOL, IDX_MONO_VOL: return 16'h8000;
      IDX_PHONE, IDX_MIC:                     return 16'h8008;
      IDX_LINE, IDX_CD, IDX_VIDEO,
      IDX_AUX, IDX_PCM_VOL:                   return 16'h8808;
      IDX_REC_GAIN:                           return 16'h8000;
      IDX_PWR:                                return 16'h000F;
      IDX_EXT_ID:                             return 16'h0A05;
      IDX_EXT_CTRL:                           return 16'h0400;
      IDX_DAC_RATE, IDX_ADC_RATE:             return RATE_MAX;
      IDX_ID_HI:                              return 16'h8384;
      IDX_ID_LO:                              return 16'h7666;
      default:                                return '0;
    endcase
  endfunction

  function automatic wr_rule_e wr_rule(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_MAIN_VOL, IDX_PCM_VOL:          return RULE_VOL;
      IDX_EXT_CTRL:                       return RULE_EXT_CTRL;
      IDX_DAC_RATE, IDX_ADC_RATE:         return RULE_RATE;
      IDX_PWR:                            return RULE_PWR;
      IDX_EXT_ID, IDX_ID_HI, IDX_ID_LO:   return RULE_RO;
      default:                            return RULE_FULL;
    endcase
  endfunction
endpackage

// File: rtl/codec_rate_snap.sv
module codec_rate_snap
  import codec_regs_pkg::*;
(
  input  logic [DATA_W-1:0] rate_i,
  output logic [DATA_W-1:0] rate_o
);
  localparam int NB = NUM_RATES - 1;

  logic [NB-1:0] below;

  // one comparator per boundary, cutoff at the integer midpoint
  for (genvar g = 0; g < NB; g++) begin : g_bnd
    localparam logic [DATA_W:0] MID =
      {1'b0, RATE_TBL[g]} + (({1'b0, RATE_TBL[g+1]} - {1'b0, RATE_TBL[g]}) >> 1);
    assign below[g] = {1'b0, rate_i} < MID;
  end

  always_comb begin
    rate_o = RATE_MAX;
    for (int i = NB - 1; i >= 0; i--) begin
      if (below[i]) rate_o = RATE_TBL[i];
    end
  end
endmodule

// File: rtl/codec_reg_array.sv
module codec_reg_array
  import codec_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rate_snap_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              vra_on;
  wr_rule_e          rule;

  assign vra_on  = regs_q[IDX_EXT_CTRL][0];
  assign rule    = wr_rule(idx_i);
  assign rdata_o = regs_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(IDX_W'(i));
    end else if (wr_en_i) begin
      case (rule)
        RULE_VOL:  regs_q[idx_i] <= wdata_i & VOL_MASK;
        RULE_EXT_CTRL: begin
          regs_q[IDX_EXT_CTRL][0] <= wdata_i[0];
          if (!wdata_i[0]) begin
            regs_q[IDX_DAC_RATE] <= RATE_MAX;
            regs_q[IDX_ADC_RATE] <= RATE_MAX;
          end
        end
        RULE_RATE: if (vra_on) regs_q[idx_i] <= rate_snap_i;
        RULE_PWR:  regs_q[idx_i][DATA_W-1:8] <= wdata_i[DATA_W-1:8];
        RULE_RO:   ;
        default:   regs_q[idx_i] <= wdata_i;
      endcase
    end
  end
endmodule

// File: rtl/codec_cmd_fmt.sv
module codec_cmd_fmt
  import codec_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CMD_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [CMD_W-1:0]  cmd_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;

  always_comb begin
    if (wdata_i[RD_SEL_BIT]) begin
      cmd_d = (wdata_i & RD_KEEP_MASK) | CMD_W'(reg_rdata_i);
      cmd_d[RD_VALID_BIT] = 1'b1;
    end else begin
      cmd_d = wdata_i & WR_KEEP_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmd_q <= '0;
    else if (we_i) cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/codec_cmd_regfile.sv
module codec_cmd_regfile
  import codec_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  output logic [CMD_W-1:0] cmd_rdata_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wr_data, snapped, reg_rdata;
  logic              reg_wr;

  // odd byte address aliases to its even entry
  assign idx     = cmd_wdata_i[16+ADDR_W-1:17];
  assign wr_data = cmd_wdata_i[DATA_W-1:0];
  assign reg_wr  = cmd_we_i & ~cmd_wdata_i[RD_SEL_BIT];

  codec_rate_snap u_snap (
    .rate_i (wr_data),
    .rate_o (snapped)
  );

  codec_reg_array u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_wr),
    .idx_i       (idx),
    .wdata_i     (wr_data),
    .rate_snap_i (snapped),
    .rdata_o     (reg_rdata)
  );

  codec_cmd_fmt u_fmt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cmd_we_i),
    .wdata_i     (cmd_wdata_i),
    .reg_rdata_i (reg_rdata),
    .cmd_o       (cmd_rdata_o)
  );
endmodule

// File: rtl/codec_cmd_regfile_chk.sv
module codec_cmd_regfile_chk
  import codec_regs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_we_i,
  input logic [CMD_W-1:0] cmd_wdata_i,
  input logic [CMD_W-1:0] cmd_rdata_o
);
  logic rd_cmd, wr_cmd;
  logic [IDX_W-1:0] cidx;
  assign rd_cmd = cmd_we_i &  cmd_wdata_i[RD_SEL_BIT];
  assign wr_cmd = cmd_we_i & ~cmd_wdata_i[RD_SEL_BIT];
  assign cidx   = cmd_wdata_i[22:17];

  function automatic logic in_rate_list(input logic [DATA_W-1:0] v);
    logic hit = 1'b0;
    for (int i = 0; i < NUM_RATES; i++) if (v == RATE_TBL[i]) hit = 1'b1;
    return hit;
  endfunction

  // R2
  wr_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> cmd_rdata_o == ($past(cmd_wdata_i) & 32'hC0FF_FFFF));

  // R3
  rd_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> cmd_rdata_o[25] && cmd_rdata_o[29:26] == 4'h0 && !cmd_rdata_o[24] &&
               cmd_rdata_o[31:30] == $past(cmd_wdata_i[31:30]) &&
               cmd_rdata_o[23:16] == $past(cmd_wdata_i[23:16]));

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> $stable(cmd_rdata_o));

  // R10
  ro_id_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && cidx == IDX_ID_HI |=> cmd_rdata_o[15:0] == 16'h8384);

  // R10
  ro_id_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && cidx == IDX_ID_LO |=> cmd_rdata_o[15:0] == 16'h7666);

  // R10
  ro_ext_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && cidx == IDX_EXT_ID |=> cmd_rdata_o[15:0] == 16'h0A05);

  // R4
  vol_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && (cidx == IDX_MAIN_VOL || cidx == IDX_PCM_VOL)
      |=> (cmd_rdata_o[15:0] & ~VOL_MASK) == 16'h0);

  // R8
  rate_member_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && (cidx == IDX_DAC_RATE || cidx == IDX_ADC_RATE)
      |=> in_rate_list(cmd_rdata_o[15:0]));
endmodule

bind codec_cmd_regfile codec_cmd_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_wdata_i (cmd_wdata_i),
  .cmd_rdata_o (cmd_rdata_o)
);

// File: tb/codec_cmd_regfile_bench.sv
module codec_cmd_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  codec_cmd_regfile u_codec_cmd_regfile (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we),
    .cmd_wdata_i(cmd_wdata), .cmd_rdata_o(cmd_rdata)
  );

  function automatic logic [15:0] def_val(input int i);
    case (i)
      8'h00: return 16'h6A90;
      8'h01, 8'h02, 8'h03, 8'h0E: return 16'h8000;
      8'h06, 8'h07: return 16'h8008;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C: return 16'h8808;
      8'h13: return 16'h000F;
      8'h14: return 16'h0A05;
      8'h15: return 16'h0400;
      8'h16, 8'h19: return 16'd48000;
      8'h3E: return 16'h8384;
      8'h3F: return 16'h7666;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] snap(input logic [15:0] v);
    int tbl [7] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
    for (int i = 0; i < 6; i++)
      if (int'(v) < tbl[i] + (tbl[i+1] - tbl[i]) / 2) return 16'(tbl[i]);
    return 16'd48000;
  endfunction

  function automatic void model_write(input logic [6:0] addr, input logic [15:0] d);
    int i = int'(addr[6:1]);
    case (i)
      8'h01, 8'h0C: model[i] = d & 16'h9F1F;
      8'h15: begin
        model[i][0] = d[0];
        if (!d[0]) begin model[8'h16] = 16'd48000; model[8'h19] = 16'd48000; end
      end
      8'h16, 8'h19: if (model[8'h15][0]) model[i] = snap(d);
      8'h13: model[i][15:8] = d[15:8];
      8'h14, 8'h3E, 8'h3F: ;
      default: model[i] = d;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [6:0] a, input logic [15:0] d);
    logic [31:0] w = {$urandom_range(3,0) > 1 ? 2'b11 : 2'b00, 6'h0, 1'b0, a, d};
    send(w);
    model_write(a, d);
    chk(tag, cmd_rdata, w & 32'hC0FF_FFFF);
  endtask

  task automatic rd(input string tag, input logic [6:0] a);
    logic [31:0] w = {2'($urandom), 6'($urandom), 1'b1, a, 16'($urandom)};
    logic [31:0] e = (w & 32'hC0FF_0000) | {16'h0, model[a[6:1]]};
    e[25] = 1'b1;
    send(w);
    chk(tag, cmd_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = def_val(i);
    repeat (3) @(negedge clk);
    chk("R1 cmd reset", cmd_rdata, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) rd("R1 default", 7'(i * 2));

    wr("R2 plain store", 7'h20, 16'hBEEF);  rd("R2 plain read", 7'h20);
    wr("R4 main vol", 7'h02, 16'hFFFF);     rd("R4 main vol", 7'h02);
    wr("R4 pcm vol", 7'h18, 16'hFFFF);      rd("R4 pcm vol", 7'h18);
    wr("R7 rate no vra", 7'h2C, 16'd8000);  rd("R7 dac ignored", 7'h2C);
    wr("R7 rate no vra", 7'h32, 16'd11025); rd("R7 adc ignored", 7'h32);
    wr("R5 ext ctrl", 7'h2A, 16'hFFFF);     rd("R5 only bit0", 7'h2A);
    begin
      logic [15:0] pts [10] = '{16'd0, 16'd9511, 16'd9512, 16'd13511, 16'd13512,
                                16'd27025, 16'd38049, 16'd46049, 16'd46050, 16'hFFFF};
      for (int k = 0; k < 10; k++) begin
        wr("R8 snap dac", 7'h2C, pts[k]); rd("R8 snap dac", 7'h2C);
        wr("R8 snap adc", 7'h32, pts[9-k]); rd("R8 snap adc", 7'h32);
      end
    end
    wr("R6 clear vra", 7'h2A, 16'h0000);
    rd("R6 dac 48k", 7'h2C); rd("R6 adc 48k", 7'h32); rd("R5 ext ctrl", 7'h2A);
    wr("R9 pwr", 7'h26, 16'hABCD);          rd("R9 pwr low kept", 7'h26);
    wr("R10 ro", 7'h28, 16'h1234);          rd("R10 ext id", 7'h28);
    wr("R10 ro", 7'h7C, 16'h1234);          rd("R10 id hi", 7'h7C);
    wr("R10 ro", 7'h7E, 16'h1234);          rd("R10 id lo", 7'h7E);
    wr("R11 odd", 7'h11, 16'h5A5A);         rd("R11 even alias", 7'h10);
    rd("R11 odd read", 7'h11);
    hold = cmd_rdata;
    repeat (5) @(negedge clk);
    chk("R12 idle hold", cmd_rdata, hold);

    for (int n = 0; n < 400; n++) begin
      logic [6:0] a = 7'($urandom);
      if ($urandom_range(3, 0) == 0) a = ($urandom_range(1, 0) != 0) ? 7'h2A : 7'h2C;
      if ($urandom_range(1, 0) != 0) wr("R2 random store", a, 16'($urandom));
      else rd("R3 random read", a);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule